// File: doc/BRIEF.md
# Full-Address DMA Transfer Channel

This block is a single DMA channel that moves data between two memory locations held in its own pair of address registers: one register always names the place being read, the other the place being written. Software programs the two addresses, a transfer count, a block size and a configuration word through a small register port. It then sets a channel enable bit and a master enable bit. From then on, a rising request on the selected activation line starts transfer work. Each data unit is moved over a simple master port as a read cycle followed by a write cycle.

The channel has two operating modes. In normal mode, each accepted request moves exactly one unit, and the count register counts units. In block mode, each accepted request moves a whole block back to back, and the count register counts blocks. The channel clears its own enable bit once the count runs out. It then flags completion, which can raise an interrupt. The channel can also pulse a clear line back to the source that activated it, so that the source drops its request.

Top module: `fa_dma_channel`

## Requirements
- R1: After reset every register reads 0, no memory access is issued, `irq` is low and `srcClr` is all zero. Register offsets: 0 source address, 1 destination address, 2 count, 3 block size, 4 configuration, 5 control.
- R2: A request is accepted only while the channel is idle and the control register has bit 0 (channel enable) and bit 1 (master enable) both at 1. The accepted request must arrive on the `reqIn` line whose index equals configuration bits [12:9]. Any other request is ignored: it causes no bus access and leaves the count unchanged.
- R3: Each data unit takes two cycles. In the first, `memRe` is high and `memAddr` is the source address. In the second, `memWe` is high, `memAddr` is the destination address and `memWdata` carries the data returned in the first cycle. The first read appears in the cycle after the clock edge that samples the request.
- R4: Configuration bits [2:1] set the source address mode and bits [4:3] set the destination address mode. The encodings are 1 for increment, 2 for decrement, and 0 or 3 for fixed. After each unit, the address steps by 1 for byte units or by 2 for word units; a fixed address does not change.
- R5: Configuration bit 0 selects word units (1) or byte units (0), and `memWord` follows it. A byte write carries the read byte on `memWdata[7:0]` with the upper bits zero.
- R6: In normal mode, each accepted request moves one unit and decrements the count register by one.
- R7: Block mode is active when configuration bit 6 (full address) and bit 5 (block) are both 1. In block mode, one accepted request moves a block-size number of units back to back, with a block size of 0 meaning 256. The count register then drops by one per block.
- R8: With bit 5 set and bit 6 clear, the channel runs in normal mode.
- R9: When the count reaches zero, the channel enable bit clears and the done flag (control bit 2, read only) sets. `irq` equals the done flag ANDed with configuration bit 7. Any write to the control register clears the done flag.
- R10: Writes to offsets 0 to 4 are ignored while the channel enable bit is 1.
- R11: When configuration bit 8 is 1, `srcClr` pulses high for one cycle on the selected line during the first read of an accepted request; otherwise `srcClr` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for regAddr (combinational) |
| reqIn | input | 16 | Activation request lines |
| srcClr | output | 16 | One-cycle clear pulse to the activating source |
| memRe | output | 1 | Memory read cycle |
| memWe | output | 1 | Memory write cycle |
| memWord | output | 1 | Unit size: 1 word, 0 byte |
| memAddr | output | 16 | Memory address |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data, valid in the read cycle |
| irq | output | 1 | Transfer-end interrupt |

## Verification
A wrong internal state shows up at the master port in the very cycle it matters. A miscounted block counter lengthens or cuts short the back-to-back read/write run. A wrong address register or step puts a wrong address on `memAddr` at the next unit. A stale data latch puts a wrong value on `memWdata` in the write cycle. Errors in the count register or the enable bits surface later: either a request that should be ignored produces a read in the following cycle, or the done flag and `irq` fail to rise one cycle after the final write. The bench therefore predicts the exact bus activity of every cycle and reads the registers back after each sequence.

// File: rtl/fa_dma_pkg.sv
package fa_dma_pkg;

  localparam int SEL_W = 4;

  localparam logic [2:0] REG_SRC  = 3'd0;
  localparam logic [2:0] REG_DST  = 3'd1;
  localparam logic [2:0] REG_CNT  = 3'd2;
  localparam logic [2:0] REG_BSZ  = 3'd3;
  localparam logic [2:0] REG_CFG  = 3'd4;
  localparam logic [2:0] REG_CTRL = 3'd5;

  typedef enum logic [1:0] {
    AM_FIXED = 2'd0,
    AM_INC   = 2'd1,
    AM_DEC   = 2'd2,
    AM_HOLD  = 2'd3
  } addrMode_e;

  // configuration word, bit 0 at the bottom
  typedef struct packed {
    logic [SEL_W-1:0] srcSel;
    logic             clrSrc;
    logic             irqEn;
    logic             fullAddr;
    logic             blockEn;
    addrMode_e        dstMode;
    addrMode_e        srcMode;
    logic             unitWord;
  } chanCfg_t;

  // control -> datapath strobes
  typedef struct packed {
    logic doRead;
    logic doWrite;
    logic firstUnit;
  } xferStb_t;

endpackage

// File: rtl/fa_dma_dpath.sv
module fa_dma_dpath
  import fa_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrSrc,
  input  logic              wrDst,
  input  logic [REG_W-1:0]  wdata,
  input  xferStb_t          stb,
  input  logic              unitWord,
  input  addrMode_e         srcMode,
  input  addrMode_e         dstMode,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);

  localparam int NUM_PTR = 2;
  localparam logic [ADDR_W-1:0] STEP_BYTE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(2);

  logic [ADDR_W-1:0] stepSize;
  logic [DATA_W-1:0] dataLat;

  assign stepSize = unitWord ? STEP_WORD : STEP_BYTE;

  // slot 0 = source pointer, slot 1 = destination pointer
  for (genvar g = 0; g < NUM_PTR; g++) begin : slot
    logic [ADDR_W-1:0] areg;
    addrMode_e         mode;
    logic              adv;
    logic              load;

    assign mode = (g == 0) ? srcMode : dstMode;
    assign adv  = (g == 0) ? stb.doRead : stb.doWrite;
    assign load = (g == 0) ? wrSrc : wrDst;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        areg <= '0;
      end else if (load) begin
        areg <= wdata[ADDR_W-1:0];
      end else if (adv) begin
        case (mode)
          AM_INC:  areg <= areg + stepSize;
          AM_DEC:  areg <= areg - stepSize;
          default: areg <= areg;
        endcase
      end
    end
  end

  assign srcAddr = slot[0].areg;
  assign dstAddr = slot[1].areg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataLat <= '0;
    end else if (stb.doRead) begin
      dataLat <= memRdata;
    end
  end

  assign memAddr  = stb.doWrite ? dstAddr : srcAddr;
  assign memWdata = unitWord ? dataLat : {{(DATA_W-8){1'b0}}, dataLat[7:0]};

  p_fixed_src_r4 : assert property (@(posedge clk) disable iff (!rstN)
    (stb.doRead && !wrSrc && (srcMode == AM_FIXED || srcMode == AM_HOLD)) |=> $stable(srcAddr))
    else $error("fixed source address moved");

  p_dst_quiet_r3 : assert property (@(posedge clk) disable iff (!rstN)
    (!stb.doWrite && !wrDst) |=> $stable(dstAddr))
    else $error("destination moved outside a write cycle");

endmodule

// File: rtl/fa_dma_ctrl.sv
module fa_dma_ctrl
  import fa_dma_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BSZ_W = 8,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrCnt,
  input  logic             wrBsz,
  input  logic             wrCfg,
  input  logic             wrCtrl,
  input  logic [REG_W-1:0] wdata,
  input  logic             reqSel,
  output chanCfg_t         cfg,
  output logic [CNT_W-1:0] cnt,
  output logic [BSZ_W-1:0] bsz,
  output logic             chanEn,
  output logic             masterEn,
  output logic             done,
  output xferStb_t         stb
);

  localparam int BLK_W   = BSZ_W + 1;
  localparam int CFG_W   = $bits(chanCfg_t);
  localparam logic [BLK_W-1:0] BLK_ONE  = BLK_W'(1);
  localparam logic [BLK_W-1:0] BLK_FULL = BLK_W'(1) << BSZ_W;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} state_e;

  state_e           state;
  logic [BLK_W-1:0] blkLeft;
  logic [BLK_W-1:0] blkLoad;
  logic             blockMode;
  logic             runOk;
  logic             lastUnit;
  logic             lastBlock;
  logic             firstRd;

  always_comb begin
    blockMode = cfg.fullAddr & cfg.blockEn;
    runOk     = chanEn & masterEn;
    if (!blockMode)       blkLoad = BLK_ONE;
    else if (bsz == '0)   blkLoad = BLK_FULL;
    else                  blkLoad = {1'b0, bsz};
    lastUnit  = (blkLeft == BLK_ONE);
    lastBlock = (cnt == CNT_ONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cfg      <= '0;
      cnt      <= '0;
      bsz      <= '0;
      chanEn   <= 1'b0;
      masterEn <= 1'b0;
      done     <= 1'b0;
      blkLeft  <= '0;
      firstRd  <= 1'b0;
    end else begin
      firstRd <= 1'b0;
      if (wrCfg) cfg <= chanCfg_t'(wdata[CFG_W-1:0]);
      if (wrBsz) bsz <= wdata[BSZ_W-1:0];
      if (wrCnt) cnt <= wdata[CNT_W-1:0];
      if (wrCtrl) begin
        chanEn   <= wdata[0];
        masterEn <= wdata[1];
        done     <= 1'b0;
      end
      case (state)
        S_IDLE: begin
          if (runOk && reqSel) begin
            state   <= S_READ;
            blkLeft <= blkLoad;
            firstRd <= 1'b1;
          end
        end
        S_READ: state <= S_WRITE;
        S_WRITE: begin
          if (lastUnit) begin
            state <= S_IDLE;
            cnt   <= cnt - CNT_ONE;
            if (lastBlock) begin
              chanEn <= 1'b0;
              done   <= 1'b1;
            end
          end else begin
            blkLeft <= blkLeft - BLK_ONE;
            state   <= S_READ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign stb.doRead    = (state == S_READ);
  assign stb.doWrite   = (state == S_WRITE);
  assign stb.firstUnit = firstRd;

  p_idle_hold_r2 : assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !runOk) |=> (state == S_IDLE))
    else $error("transfer started while disabled");

  p_blk_bound_r7 : assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> (blkLeft != '0 && blkLeft <= BLK_FULL))
    else $error("block counter out of range");

  p_finish_r9 : assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WRITE && lastUnit && lastBlock && !wrCtrl) |=> (!chanEn && done))
    else $error("channel not stopped at end of count");

  p_cfg_lock_r10 : assert property (@(posedge clk) disable iff (!rstN)
    chanEn |=> $stable(cfg))
    else $error("configuration changed while enabled");

endmodule

// File: rtl/fa_dma_channel.sv
module fa_dma_channel
  import fa_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int BSZ_W  = 8,
  parameter int REG_W  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [2:0]           regAddr,
  input  logic [REG_W-1:0]     regWdata,
  output logic [REG_W-1:0]     regRdata,
  input  logic [(1<<SEL_W)-1:0] reqIn,
  output logic [(1<<SEL_W)-1:0] srcClr,
  output logic                 memRe,
  output logic                 memWe,
  output logic                 memWord,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [DATA_W-1:0]    memWdata,
  input  logic [DATA_W-1:0]    memRdata,
  output logic                 irq
);

  localparam int N_SRC = 1 << SEL_W;

  chanCfg_t          cfg;
  xferStb_t          stb;
  logic [CNT_W-1:0]  cnt;
  logic [BSZ_W-1:0]  bsz;
  logic              chanEn;
  logic              masterEn;
  logic              done;
  logic [ADDR_W-1:0] srcAddr;
  logic [ADDR_W-1:0] dstAddr;
  logic              cfgWrOk;
  logic              wrSrc, wrDst, wrCnt, wrBsz, wrCfg, wrCtrl;
  logic              reqSel;

  assign cfgWrOk = regWe & ~chanEn;
  assign wrSrc   = cfgWrOk && (regAddr == REG_SRC);
  assign wrDst   = cfgWrOk && (regAddr == REG_DST);
  assign wrCnt   = cfgWrOk && (regAddr == REG_CNT);
  assign wrBsz   = cfgWrOk && (regAddr == REG_BSZ);
  assign wrCfg   = cfgWrOk && (regAddr == REG_CFG);
  assign wrCtrl  = regWe && (regAddr == REG_CTRL);
  assign reqSel  = reqIn[cfg.srcSel];

  fa_dma_ctrl #(.CNT_W(CNT_W), .BSZ_W(BSZ_W), .REG_W(REG_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrCnt    (wrCnt),
    .wrBsz    (wrBsz),
    .wrCfg    (wrCfg),
    .wrCtrl   (wrCtrl),
    .wdata    (regWdata),
    .reqSel   (reqSel),
    .cfg      (cfg),
    .cnt      (cnt),
    .bsz      (bsz),
    .chanEn   (chanEn),
    .masterEn (masterEn),
    .done     (done),
    .stb      (stb)
  );

  fa_dma_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .wrSrc    (wrSrc),
    .wrDst    (wrDst),
    .wdata    (regWdata),
    .stb      (stb),
    .unitWord (cfg.unitWord),
    .srcMode  (cfg.srcMode),
    .dstMode  (cfg.dstMode),
    .memRdata (memRdata),
    .srcAddr  (srcAddr),
    .dstAddr  (dstAddr),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : clrGen
    assign srcClr[i] = stb.firstUnit & cfg.clrSrc & (cfg.srcSel == SEL_W'(i));
  end

  assign memRe   = stb.doRead;
  assign memWe   = stb.doWrite;
  assign memWord = cfg.unitWord;
  assign irq     = done & cfg.irqEn;

  always_comb begin
    case (regAddr)
      REG_SRC:  regRdata = REG_W'(srcAddr);
      REG_DST:  regRdata = REG_W'(dstAddr);
      REG_CNT:  regRdata = REG_W'(cnt);
      REG_BSZ:  regRdata = REG_W'(bsz);
      REG_CFG:  regRdata = REG_W'(cfg);
      REG_CTRL: regRdata = REG_W'({done, masterEn, chanEn});
      default:  regRdata = '0;
    endcase
  end

  p_rw_pair_r3 : assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> memWe)
    else $error("read not followed by write");

  p_clr_onehot_r11 : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(srcClr))
    else $error("more than one clear line");

  p_clr_on_read_r11 : assert property (@(posedge clk) disable iff (!rstN)
    (srcClr != '0) |-> memRe)
    else $error("clear pulse outside a read cycle");

endmodule

// File: tb/tb_fa_dma_channel.sv
`timescale 1ns/1ps
module tb_fa_dma_channel;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWe;
  logic [2:0]  regAddr;
  logic [15:0] regWdata;
  logic [15:0] regRdata;
  logic [15:0] reqIn;
  logic [15:0] srcClr;
  logic        memRe, memWe, memWord;
  logic [15:0] memAddr, memWdata, memRdata;
  logic        irq;

  always #2.5 clk = ~clk;

  fa_dma_channel dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .reqIn(reqIn), .srcClr(srcClr),
    .memRe(memRe), .memWe(memWe), .memWord(memWord), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .irq(irq)
  );

  // memory model: combinational read, write on clock edge
  logic [7:0] mem [0:1023];
  assign memRdata = {mem[memAddr[9:0] + 10'd1], mem[memAddr[9:0]]};
  always @(posedge clk) begin
    if (memWe) begin
      mem[memAddr[9:0]] <= memWdata[7:0];
      if (memWord) mem[memAddr[9:0] + 10'd1] <= memWdata[15:8];
    end
  end

  typedef struct {
    bit we;
    int addr;
    int data;
    bit word;
    bit clr;
  } op_t;
  op_t expQ[$];
  op_t cur;

  int checks = 0;
  int errors = 0;
  bit running = 0;

  // behavioural model state
  int mSrc, mDst, mCnt, mBsz, mSel, mSmode, mDmode;
  bit mWord, mBlkE, mFae, mIrqE, mClr, mEn, mMen, mDone;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int stepM(int a, int mode, bit word);
    int d = word ? 2 : 1;
    if (mode == 1) return (a + d) & 16'hFFFF;
    if (mode == 2) return (a - d) & 16'hFFFF;
    return a;
  endfunction

  // per-cycle comparison against the predicted bus activity
  always @(negedge clk) begin
    if (running) begin
      if (expQ.size() > 0) begin
        cur = expQ.pop_front();
        chk(memRe == !cur.we && memWe == cur.we && memAddr == cur.addr[15:0] &&
            memWord == cur.word && (!cur.we || memWdata == cur.data[15:0]),
            "R3 bus cycle", {memRe, memWe, memAddr, memWdata},
            {!cur.we, cur.we, cur.addr[15:0], cur.we ? cur.data[15:0] : memWdata});
        chk(srcClr == (cur.clr ? (16'd1 << mSel) : 16'd0), "R11 clear pulse",
            srcClr, cur.clr ? (1 << mSel) : 0);
      end else begin
        chk(!memRe && !memWe, "R2 R3 idle bus", {memRe, memWe}, 0);
        chk(srcClr == 16'd0, "R11 idle clear", srcClr, 0);
      end
    end
  end

  task automatic regWr(int a, int d);
    wait (expQ.size() == 0);
    @(posedge clk); #1;
    regWe = 1'b1; regAddr = a[2:0]; regWdata = d[15:0];
    @(posedge clk); #1;
    regWe = 1'b0;
    if (a == 5) begin
      mEn = d[0]; mMen = d[1]; mDone = 0;
    end else if (!mEn) begin
      case (a)
        0: mSrc = d & 16'hFFFF;
        1: mDst = d & 16'hFFFF;
        2: mCnt = d & 16'hFFFF;
        3: mBsz = d & 8'hFF;
        4: begin
          mWord = d[0]; mSmode = (d >> 1) & 3; mDmode = (d >> 3) & 3;
          mBlkE = d[5]; mFae = d[6]; mIrqE = d[7]; mClr = d[8];
          mSel = (d >> 9) & 15;
        end
        default: ;
      endcase
    end
  endtask

  task automatic regChk(int a, int exp, string tag);
    wait (expQ.size() == 0);
    @(posedge clk); #1;
    regAddr = a[2:0];
    #1;
    chk(regRdata == exp[15:0], tag, regRdata, exp);
  endtask

  task automatic irqChk(bit exp, string tag);
    wait (expQ.size() == 0);
    @(posedge clk); #1;
    chk(irq == exp, tag, irq, exp);
  endtask

  task automatic pulse(int line);
    int units;
    int data;
    op_t o;
    wait (expQ.size() == 0);
    @(posedge clk); #1;
    reqIn[line] = 1'b1;
    @(posedge clk); #1;
    reqIn = '0;
    if (line == mSel && mEn && mMen) begin
      units = (mFae && mBlkE) ? ((mBsz == 0) ? 256 : mBsz) : 1;
      for (int u = 0; u < units; u++) begin
        data = mWord ? {mem[(mSrc + 1) & 1023], mem[mSrc & 1023]} : mem[mSrc & 1023];
        o.we = 0; o.addr = mSrc; o.data = 0; o.word = mWord; o.clr = mClr && (u == 0);
        expQ.push_back(o);
        o.we = 1; o.addr = mDst; o.data = data; o.clr = 0;
        expQ.push_back(o);
        mSrc = stepM(mSrc, mSmode, mWord);
        mDst = stepM(mDst, mDmode, mWord);
      end
      mCnt = (mCnt - 1) & 16'hFFFF;
      if (mCnt == 0) begin
        mEn = 0; mDone = 1;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog R3", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 7 + 3) & 255);
    rstN = 1'b0; regWe = 1'b0; regAddr = '0; regWdata = '0; reqIn = '0;
    mSrc = 0; mDst = 0; mCnt = 0; mBsz = 0; mSel = 0; mSmode = 0; mDmode = 0;
    mWord = 0; mBlkE = 0; mFae = 0; mIrqE = 0; mClr = 0; mEn = 0; mMen = 0; mDone = 0;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    running = 1;

    // R1 reset state
    for (int a = 0; a < 6; a++) regChk(a, 0, "R1 reset register");
    irqChk(0, "R1 reset irq");

    // normal mode, byte units, both increment, select line 2
    regWr(0, 'h10); regWr(1, 'h100); regWr(2, 3);
    regWr(4, 'h48A); regWr(5, 3);
    pulse(2); pulse(2);
    pulse(5);
    regChk(2, 1, "R2 unselected line ignored");
    pulse(2);
    regChk(0, 'h13, "R4 source incremented by 1");
    regChk(1, 'h103, "R4 destination incremented by 1");
    regChk(2, 0, "R6 count per unit");
    regChk(5, 6, "R9 enable cleared, done set");
    irqChk(1, "R9 irq raised");
    chk(mem[10'h101] == 8'h7A, "R5 byte copied", mem[10'h101], 'h7A);
    chk(mem[10'h103] == 8'h18, "R5 byte unit leaves neighbour", mem[10'h103], 'h18);
    pulse(2);
    regChk(0, 'h13, "R2 request after finish ignored");
    regWr(5, 2);
    irqChk(0, "R9 control write clears done");

    // write lockout while enabled
    regWr(5, 3);
    regWr(0, 'h55);
    regWr(2, 9);
    regChk(0, 'h13, "R10 address write ignored");
    regChk(2, 0, "R10 count write ignored");
    regWr(5, 0);

    // word units, source decrement, destination fixed, clear enabled, line 7
    regWr(0, 'h200); regWr(1, 'h300); regWr(2, 2); regWr(4, 'hF05);
    regWr(5, 1);
    pulse(7);
    regChk(2, 2, "R2 master enable off ignores request");
    regWr(5, 3);
    pulse(7); pulse(7);
    regChk(0, 'h1FC, "R4 source decremented by 2");
    regChk(1, 'h300, "R4 fixed destination");
    chk({mem[10'h301], mem[10'h300]} == 16'hFCF5, "R5 word copied",
        {mem[10'h301], mem[10'h300]}, 'hFCF5);
    regChk(5, 6, "R9 done without interrupt");
    irqChk(0, "R9 irq masked");
    regWr(5, 0);

    // block mode: 2 blocks of 3 bytes
    regWr(0, 'h20); regWr(1, 'h140); regWr(2, 2); regWr(3, 3); regWr(4, 'hEA);
    regWr(5, 3);
    pulse(0);
    regChk(2, 1, "R7 count per block");
    pulse(0);
    regChk(0, 'h26, "R7 block moved three units each");
    regChk(1, 'h146, "R7 destination after two blocks");
    irqChk(1, "R9 irq after blocks");

    // block bit without full-address bit stays in normal mode
    regWr(5, 2);
    regWr(2, 2); regWr(4, 'h2A);
    regWr(5, 3);
    pulse(0);
    regChk(2, 1, "R8 normal mode count");
    regChk(0, 'h27, "R8 single unit moved");
    regWr(5, 2);

    // block size 0 means 256 units
    regWr(0, 'h0); regWr(1, 'h200); regWr(2, 1); regWr(3, 0); regWr(4, 'hEA);
    regWr(5, 3);
    pulse(0);
    regChk(0, 'h100, "R7 size zero source");
    regChk(1, 'h300, "R7 size zero destination");
    regChk(5, 6, "R9 finished after one block");

    repeat (5) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule